// File: doc/BRIEF.md
# RF Front-End Timing Strobe Generator

This block produces the control lines for an external radio module in a time-division framed link. It runs two frame counters from one programmable frame length. The transmit counter runs freely. The receive counter can be restarted by an alignment pulse from the frame synchronizer. Each output line is a window that opens at one programmed position and closes at another. The block compares these positions with one of the two counters. It then applies a per-line polarity and a global sleep gate, and registers the result.

The outputs are:
- a radio power enable;
- a transmit-section enable;
- a receive-section enable;
- a receiver-on line;
- a one-cycle modulator start strobe;
- a synthesizer load-enable pulse.

The leading edge of the load-enable pulse tells the synthesizer to hop to its next channel. Software writes a shadow register file. The shadow contents are copied into the working set only when the transmit frame wraps, so no window is cut short partway through a frame.

Top module: `rf_strobe_gen`

## Requirements
- R1: While `rst` is high, every output is 0 and both counters are cleared. After reset the frame length is the parameter `DEF_LEN`, all positions and control bits are 0, and every output reflects the cycle before it (one register stage).
- R2: Each counter steps by one per clock. A counter returns to 0 on the clock after it holds a value at or above frame length minus one. The receive counter also returns to 0 on the clock after `rx_align_i` is high.
- R3: A window is open for a count c when on <= c < off. When off < on, the window wraps and is open for c >= on or c < off. When on equals off, the window never opens.
- R4: When awake, `rf_pwr_o` is 1 XOR the power polarity bit. In sleep, it is 0 XOR that bit.
- R5: `tx_sec_o` is the window (transmit on, transmit off) on the transmit counter. It is ANDed with the transmit enable bit and then XORed with the transmit polarity bit.
- R6: `rx_on_o` is the window (demod on, demod off) on the receive counter, XORed with the receive polarity bit.
- R7: `rx_sec_o` is the window (receive-section on, receive-section off) evaluated on the transmit counter, not the receive counter. It is XORed with the receive polarity bit.
- R8: One receive polarity bit sets the active level of both `rx_sec_o` and `rx_on_o`. A polarity bit of 1 makes a line active-low.
- R9: `mod_start_o` is high for the cycle after the transmit counter equals the modulator position, and only when transmit enable is set and the block is awake. It has no polarity.
- R10: When hop enable is set and the block is awake, the load-enable line is active while the transmit count is below `LE_CYC` (4). This gives a pulse of that many cycles that starts at count 0. `synth_le_o` is that level XORed with its own polarity bit.
- R11: While `sleep_i` is high, every window, the strobe and the load-enable line are held at their inactive levels after polarity. The power line is deasserted.
- R12: Writes go to a shadow copy and become active only on the clock where the transmit counter wraps. The register map is:

  | Address | Contents |
  |---|---|
  | 0 | frame length |
  | 1 | transmit on |
  | 2 | transmit off |
  | 3 | receive-section on |
  | 4 | receive-section off |
  | 5 | demod on |
  | 6 | demod off |
  | 7 | modulator position |
  | 8 | control |
  | 9 to 15 | ignored |

  Control bits:

  | Bit | Meaning |
  |---|---|
  | 0 | transmit enable |
  | 1 | hop enable |
  | 2 | power polarity |
  | 3 | transmit polarity |
  | 4 | receive polarity |
  | 5 | load-enable polarity |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep request; forces all lines inactive |
| rx_align_i | input | 1 | Restarts the receive frame counter |
| cfg_we_i | input | 1 | Shadow register write strobe |
| cfg_addr_i | input | 4 | Shadow register address |
| cfg_wdata_i | input | 12 | Shadow register write data |
| rf_pwr_o | output | 1 | Radio module power enable |
| tx_sec_o | output | 1 | Transmit section enable |
| rx_sec_o | output | 1 | Receive section enable |
| rx_on_o | output | 1 | Receiver-on line |
| mod_start_o | output | 1 | Modulator start strobe |
| synth_le_o | output | 1 | Synthesizer load-enable pulse |

## Verification
The bench first offsets the receive counter from the transmit counter. A design that timed the receive-section line from the receive counter would then open it at the wrong counts. It also drives windows that wrap across the frame end and windows whose on and off positions are equal. A comparator that ignored wraparound, or that treated an equal pair as a full frame, would show the line at the wrong counts. The bench writes registers, including a shorter frame length, in the middle of a frame. A design that applied them at once would change line timing or the wrap point before the boundary. Sleep is raised across a frame boundary while every polarity is inverted. A design that gated sleep before polarity, or that split the shared receive polarity, would drive the wrong levels.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int CNT_W  = 12;
  localparam int ADDR_W = 4;
  localparam int WIN_N  = 3;

  typedef logic [CNT_W-1:0] pos_t;

  typedef struct packed {
    pos_t frame_len;
    pos_t tx_on;
    pos_t tx_off;
    pos_t rs_on;
    pos_t rs_off;
    pos_t dm_on;
    pos_t dm_off;
    pos_t mod_on;
    logic le_pol;
    logic rx_pol;
    logic tx_pol;
    logic pwr_pol;
    logic hop_en;
    logic tx_en;
  } cfg_t;

  typedef enum logic [ADDR_W-1:0] {
    A_LEN   = 4'd0,
    A_TXON  = 4'd1,
    A_TXOFF = 4'd2,
    A_RSON  = 4'd3,
    A_RSOFF = 4'd4,
    A_DMON  = 4'd5,
    A_DMOFF = 4'd6,
    A_MODON = 4'd7,
    A_CTRL  = 4'd8
  } addr_e;

  // window slot indices
  localparam int W_TXSEC = 0;
  localparam int W_RXSEC = 1;
  localparam int W_RXON  = 2;
endpackage

// File: rtl/rfs_cfg_regs.sv
module rfs_cfg_regs
  import rfs_pkg::*;
#(
  parameter pos_t DEF_LEN = 12'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  pos_t              wdata,
  input  logic              commit,
  output cfg_t              act
);
  localparam cfg_t CFG_RST = '{frame_len: DEF_LEN, default: '0};

  cfg_t shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= CFG_RST;
    end else if (we) begin
      case (addr_e'(addr))
        A_LEN:   shadow.frame_len <= wdata;
        A_TXON:  shadow.tx_on     <= wdata;
        A_TXOFF: shadow.tx_off    <= wdata;
        A_RSON:  shadow.rs_on     <= wdata;
        A_RSOFF: shadow.rs_off    <= wdata;
        A_DMON:  shadow.dm_on     <= wdata;
        A_DMOFF: shadow.dm_off    <= wdata;
        A_MODON: shadow.mod_on    <= wdata;
        A_CTRL: begin
          shadow.tx_en   <= wdata[0];
          shadow.hop_en  <= wdata[1];
          shadow.pwr_pol <= wdata[2];
          shadow.tx_pol  <= wdata[3];
          shadow.rx_pol  <= wdata[4];
          shadow.le_pol  <= wdata[5];
        end
        default: ;
      endcase
    end
  end

  // working set moves only at the transmit frame wrap
  always_ff @(posedge clk) begin
    if (rst)         act <= CFG_RST;
    else if (commit) act <= shadow;
  end

  assert_commit_at_wrap_R12: assert property (@(posedge clk) disable iff (rst)
    (act != $past(act)) |-> $past(commit));
endmodule

// File: rtl/rfs_frame_counter.sv
module rfs_frame_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] last_pos;
  assign last_pos = len - CW'(1);

  always_ff @(posedge clk) begin
    if (rst || restart)       cnt <= '0;
    else if (cnt >= last_pos) cnt <= '0;
    else                      cnt <= cnt + CW'(1);
  end

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt >= last_pos) |=> (cnt == '0));
endmodule

// File: rtl/rfs_window.sv
module rfs_window #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on,
  input  logic [CW-1:0] off,
  output logic          hit
);
  always_comb begin
    if (on <= off) hit = (cnt >= on) && (cnt < off);
    else           hit = (cnt >= on) || (cnt < off);
  end
endmodule

// File: rtl/rf_strobe_gen.sv
module rf_strobe_gen
  import rfs_pkg::*;
#(
  parameter pos_t DEF_LEN = 12'd64,
  parameter int   LE_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              rx_align_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  output logic              rf_pwr_o,
  output logic              tx_sec_o,
  output logic              rx_sec_o,
  output logic              rx_on_o,
  output logic              mod_start_o,
  output logic              synth_le_o
);
  cfg_t cfg;
  pos_t tx_cnt, rx_cnt;
  logic commit;

  assign commit = (tx_cnt >= cfg.frame_len - pos_t'(1));

  rfs_cfg_regs #(.DEF_LEN(DEF_LEN)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we_i), .addr(cfg_addr_i),
    .wdata(cfg_wdata_i), .commit(commit), .act(cfg)
  );

  rfs_frame_counter #(.CW(CNT_W)) u_tx_cnt (
    .clk(clk), .rst(rst), .restart(1'b0), .len(cfg.frame_len), .cnt(tx_cnt)
  );

  rfs_frame_counter #(.CW(CNT_W)) u_rx_cnt (
    .clk(clk), .rst(rst), .restart(rx_align_i), .len(cfg.frame_len), .cnt(rx_cnt)
  );

  // window slots: receive section runs off the transmit counter
  pos_t w_cnt [WIN_N];
  pos_t w_on  [WIN_N];
  pos_t w_off [WIN_N];
  logic [WIN_N-1:0] w_hit;

  assign w_cnt[W_TXSEC] = tx_cnt;
  assign w_on [W_TXSEC] = cfg.tx_on;
  assign w_off[W_TXSEC] = cfg.tx_off;
  assign w_cnt[W_RXSEC] = tx_cnt;
  assign w_on [W_RXSEC] = cfg.rs_on;
  assign w_off[W_RXSEC] = cfg.rs_off;
  assign w_cnt[W_RXON]  = rx_cnt;
  assign w_on [W_RXON]  = cfg.dm_on;
  assign w_off[W_RXON]  = cfg.dm_off;

  for (genvar g = 0; g < WIN_N; g++) begin : g_win
    rfs_window #(.CW(CNT_W)) u_win (
      .cnt(w_cnt[g]), .on(w_on[g]), .off(w_off[g]), .hit(w_hit[g])
    );
  end

  logic awake;
  logic n_txsec, n_rxsec, n_rxon, n_mod, n_le;
  assign awake   = !sleep_i;
  assign n_txsec = awake & cfg.tx_en & w_hit[W_TXSEC];
  assign n_rxsec = awake & w_hit[W_RXSEC];
  assign n_rxon  = awake & w_hit[W_RXON];
  assign n_mod   = awake & cfg.tx_en & (tx_cnt == cfg.mod_on);
  assign n_le    = awake & cfg.hop_en & (tx_cnt < pos_t'(LE_CYC));

  // raw (pre-polarity) copies kept for the checks below
  logic r_txsec, r_rxsec, r_rxon, r_le, slept_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      {r_txsec, r_rxsec, r_rxon, r_le, slept_q} <= '0;
      {rf_pwr_o, tx_sec_o, rx_sec_o, rx_on_o, mod_start_o, synth_le_o} <= '0;
    end else begin
      r_txsec     <= n_txsec;
      r_rxsec     <= n_rxsec;
      r_rxon      <= n_rxon;
      r_le        <= n_le;
      slept_q     <= sleep_i;
      rf_pwr_o    <= awake   ^ cfg.pwr_pol;
      tx_sec_o    <= n_txsec ^ cfg.tx_pol;
      rx_sec_o    <= n_rxsec ^ cfg.rx_pol;
      rx_on_o     <= n_rxon  ^ cfg.rx_pol;
      mod_start_o <= n_mod;
      synth_le_o  <= n_le    ^ cfg.le_pol;
    end
  end

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_i) |-> !(r_txsec || r_rxsec || r_rxon || r_le || mod_start_o));

  assert_mod_on_match_R9: assert property (@(posedge clk) disable iff (rst)
    mod_start_o |-> ($past(tx_cnt) == $past(cfg.mod_on)) && !$past(sleep_i));

  assert_le_starts_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(r_le) |-> ($past(tx_cnt) == '0) || $past(slept_q));

  assert_pwr_level_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rf_pwr_o == ($past(!sleep_i) ^ $past(cfg.pwr_pol))));
endmodule

// File: tb/rf_strobe_gen_tb.sv
`timescale 1ns/1ps
module rf_strobe_gen_tb;
  localparam logic [11:0] DEF_LEN = 12'd64;
  localparam int          LE_CYC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0, rx_align_i = 1'b0, cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [11:0] cfg_wdata_i = '0;
  logic rf_pwr_o, tx_sec_o, rx_sec_o, rx_on_o, mod_start_o, synth_le_o;

  always #5 clk = ~clk;

  rf_strobe_gen #(.DEF_LEN(DEF_LEN), .LE_CYC(LE_CYC)) u_dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .rx_align_i(rx_align_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .rf_pwr_o(rf_pwr_o), .tx_sec_o(tx_sec_o), .rx_sec_o(rx_sec_o),
    .rx_on_o(rx_on_o), .mod_start_o(mod_start_o), .synth_le_o(synth_le_o)
  );

  typedef struct {
    logic  pwr, txs, rxs, rxo, mod, le;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string ph = "R1";

  // reference state built from the requirements
  logic [11:0] m_sh [9];
  logic [11:0] m_ac [9];
  logic [11:0] m_tx, m_rx, m_len;
  logic        aw;
  exp_t        e;

  function automatic logic inwin(logic [11:0] c, logic [11:0] a, logic [11:0] b);
    if (a <= b) return (c >= a) && (c < b);
    return (c >= a) || (c < b);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 9; i++) begin m_sh[i] = '0; m_ac[i] = '0; end
      m_sh[0] = DEF_LEN; m_ac[0] = DEF_LEN;
      m_tx = '0; m_rx = '0;
      e.pwr = 0; e.txs = 0; e.rxs = 0; e.rxo = 0; e.mod = 0; e.le = 0;
      e.tag = "R1";
    end else begin
      aw    = !sleep_i;
      e.pwr = aw ^ m_ac[8][2];
      e.txs = (aw & m_ac[8][0] & inwin(m_tx, m_ac[1], m_ac[2])) ^ m_ac[8][3];
      e.rxs = (aw & inwin(m_tx, m_ac[3], m_ac[4])) ^ m_ac[8][4];
      e.rxo = (aw & inwin(m_rx, m_ac[5], m_ac[6])) ^ m_ac[8][4];
      e.mod = aw & m_ac[8][0] & (m_tx == m_ac[7]);
      e.le  = (aw & m_ac[8][1] & (m_tx < 12'(LE_CYC))) ^ m_ac[8][5];
      e.tag = sleep_i ? "R11" : ph;
      m_len = m_ac[0] - 12'd1;
      if (rx_align_i || m_rx >= m_len) m_rx = '0; else m_rx = m_rx + 12'd1;
      if (m_tx >= m_len) begin
        m_tx = '0;
        for (int i = 0; i < 9; i++) m_ac[i] = m_sh[i];
      end else begin
        m_tx = m_tx + 12'd1;
      end
      if (cfg_we_i && cfg_addr_i < 4'd9) m_sh[cfg_addr_i] = cfg_wdata_i;
    end
    q.push_back(e);
  end

  task automatic chk(string req, string tag, string nm, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) %s: got %b expected %b at %0t", req, tag, nm, got, exp, $time);
    end
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk("R4", x.tag, "rf_pwr_o",    rf_pwr_o,    x.pwr);
      chk("R5", x.tag, "tx_sec_o",    tx_sec_o,    x.txs);
      chk("R7", x.tag, "rx_sec_o",    rx_sec_o,    x.rxs);
      chk("R6", x.tag, "rx_on_o",     rx_on_o,     x.rxo);
      chk("R9", x.tag, "mod_start_o", mod_start_o, x.mod);
      chk("R10", x.tag, "synth_le_o", synth_le_o,  x.le);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    ph = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12: writes stay in shadow until the default 64-count frame wraps
    ph = "R12";
    wr(4'd0, 12'd20);
    wr(4'd1, 12'd3);  wr(4'd2, 12'd8);
    wr(4'd3, 12'd15); wr(4'd4, 12'd4);   // wrapping receive-section window
    wr(4'd5, 12'd5);  wr(4'd6, 12'd12);
    wr(4'd7, 12'd2);
    wr(4'd8, 12'h003);                   // transmit enable, hop enable
    wr(4'd12, 12'hFFF);                  // unused address, ignored
    idle(70);
    // R3: plain and wrapping windows over 20-count frames
    ph = "R3";
    idle(45);
    // R2: receive counter offset; receive section must stay on transmit count
    ph = "R2";
    idle(6);
    rx_align_i = 1'b1; @(negedge clk); rx_align_i = 1'b0;
    idle(45);
    // R8: all polarities inverted, shared receive polarity
    ph = "R8";
    wr(4'd8, 12'h03D);
    idle(45);
    wr(4'd8, 12'h033);
    idle(45);
    // R5: transmit enable cleared gates transmit section and strobe
    ph = "R5";
    wr(4'd8, 12'h012);
    idle(45);
    // R11: sleep across a frame boundary with polarity applied
    wr(4'd8, 12'h03F);
    idle(25);
    sleep_i = 1'b1; idle(25); sleep_i = 1'b0;
    ph = "R10";
    idle(30);
    // R3: empty window and wrapping receiver-on window
    ph = "R3";
    wr(4'd1, 12'd6); wr(4'd2, 12'd6);
    wr(4'd5, 12'd18); wr(4'd6, 12'd3);
    wr(4'd8, 12'h003);
    idle(50);
    // R12: shorter frame written mid-frame
    ph = "R12";
    idle(7);
    wr(4'd0, 12'd7); wr(4'd7, 12'd5);
    idle(40);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule